// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the register front end of a descriptor-driven DMA engine with several channels. Each channel owns a 128-byte window of 32-bit word registers, reached over a simple synchronous bus. For each channel the block stores the control/status word, the descriptor pointer and three condition-select words. It derives the run, pause, flush and wake qualifiers, the activity flags and three condition bits, and passes them to the descriptor sequencer.

Software starts, pauses and stops a channel with control writes. The upper half of a control write is a per-bit write enable and the lower half holds the new bit values. The ACTIVE and DEAD flags then follow from the resulting RUN, PAUSE and WAKE bits. The sequencer reports back kill, stop, branch-taken and flush-serviced events, and it reacts to a one-cycle load request whenever software installs a new descriptor pointer.

Top module: `dma_ctl_regs`

## Requirements
- R1: The channel index is `bus_addr[ADDR_W-1:7]` and the word index is `bus_addr[6:2]`. An access to a channel index at or above NUM_CHAN writes nothing and reads zero.
- R2: A write to word 0 (control) uses data bits 31:16 as write enables and bits 15:0 as values. Only RUN (bit 15), PAUSE (bit 14), FLUSH (bit 13), WAKE (bit 12) and device status (bits 7:0) can change. The stored bit becomes the value where its enable is set and keeps its old value elsewhere. The run/pause/flush/wake outputs follow those status bits.
- R3: After a control merge, a set WAKE forces ACTIVE (bit 10) to 1, and a set RUN forces ACTIVE to 1 and clears DEAD (bit 11).
- R4: A set PAUSE clears ACTIVE after the RUN and WAKE rules are applied, so ACTIVE is never 1 while PAUSE is 1.
- R5: A control write that takes RUN from 1 to 0 clears both ACTIVE and DEAD.
- R6: A write to word 3 (descriptor pointer) is ignored while RUN or ACTIVE is 1. An accepted write stores the data with bits 3:0 forced to zero and raises the channel's load request for exactly the following cycle.
- R7: A read returns data one cycle after the read strobe. Word 0 reads zero. Word 1 reads `{16'h0, status}`. Words 3 to 6 read their stored values. Every other word reads zero, and writes to word 1 or to unused words change nothing.
- R8: A kill event sets DEAD, clears ACTIVE and pulses the channel interrupt for exactly the following cycle. It overrides a same-cycle control write or stop.
- R9: A stop event clears ACTIVE and DEAD. A branch-update event loads BT (bit 8) from `ev_bt_val`. A flush-done event clears FLUSH and overrides a same-cycle control write.
- R10: Each condition output equals `(devstat[3:0] & sel[19:16]) == (sel[3:0] & sel[19:16])`. The select is word 4 for interrupt, word 5 for branch and word 6 for wait.
- R11: Reset clears the status, pointer and select registers of every channel, the read data, the interrupts and the load requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Word write strobe |
| bus_re | input | 1 | Word read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| ev_kill | input | NUM_CHAN | Sequencer kill event per channel |
| ev_stop | input | NUM_CHAN | Sequencer stop event per channel |
| ev_bt_upd | input | NUM_CHAN | Branch-taken update strobe |
| ev_bt_val | input | NUM_CHAN | Branch-taken value |
| flush_done | input | NUM_CHAN | Flush serviced, clears FLUSH |
| run_o | output | NUM_CHAN | RUN qualifier |
| pause_o | output | NUM_CHAN | PAUSE qualifier |
| flush_o | output | NUM_CHAN | FLUSH qualifier |
| wake_o | output | NUM_CHAN | WAKE qualifier |
| active_o | output | NUM_CHAN | ACTIVE flag |
| dead_o | output | NUM_CHAN | DEAD flag |
| irq_o | output | NUM_CHAN | One-cycle interrupt on kill |
| load_req_o | output | NUM_CHAN | One-cycle descriptor load request |
| cmd_ptr_o | output | NUM_CHAN*32 | Descriptor pointer per channel |
| int_cond_o | output | NUM_CHAN | Interrupt condition |
| br_cond_o | output | NUM_CHAN | Branch condition |
| wait_cond_o | output | NUM_CHAN | Wait condition |

## Verification
A wrong merge or a wrong flag rule changes the status word and the qualifier pins at the clock edge that takes the control write. Both are compared in the next cycle across every enable and value pattern of the four command bits. A pointer-lock error shows up as a changed pointer readback and a stray load request in the cycle after the write. A condition mismatch shows up on the condition pins as soon as the select write lands, and the sweep covers every device-status, mask and value combination.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
   localparam int DATA_W  = 32;
   localparam int STAT_W  = 16;
   localparam int WORD_W  = 5;
   localparam int WIN_LSB = 7;
   localparam int NUM_SEL = 3;

   localparam int B_RUN   = 15;
   localparam int B_PAUSE = 14;
   localparam int B_FLUSH = 13;
   localparam int B_WAKE  = 12;
   localparam int B_DEAD  = 11;
   localparam int B_ACT   = 10;
   localparam int B_BT    = 8;

   localparam logic [STAT_W-1:0] CTL_WR_MASK = 16'hF0FF;

   localparam logic [WORD_W-1:0] W_CTRL = 5'd0;
   localparam logic [WORD_W-1:0] W_STAT = 5'd1;
   localparam logic [WORD_W-1:0] W_PTR  = 5'd3;
   localparam logic [WORD_W-1:0] W_ISEL = 5'd4;

   typedef enum logic [1:0] {SEL_INT = 2'd0, SEL_BR = 2'd1, SEL_WAIT = 2'd2} sel_kind_e;

   // merge a control word into the status, then derive the activity flags
   function automatic logic [STAT_W-1:0] ctl_merge(input logic [STAT_W-1:0] old,
                                                   input logic [DATA_W-1:0] wd);
      logic [STAT_W-1:0] en, val, nx;
      en  = wd[31:16] & CTL_WR_MASK;
      val = wd[15:0] & CTL_WR_MASK;
      nx  = (val & en) | (old & ~en);
      if (nx[B_WAKE]) nx[B_ACT] = 1'b1;
      if (nx[B_RUN]) begin
         nx[B_ACT]  = 1'b1;
         nx[B_DEAD] = 1'b0;
      end
      if (nx[B_PAUSE]) nx[B_ACT] = 1'b0;
      if (old[B_RUN] && !nx[B_RUN]) begin
         nx[B_ACT]  = 1'b0;
         nx[B_DEAD] = 1'b0;
      end
      return nx;
   endfunction

   function automatic logic sel_match(input logic [3:0] dstat, input logic [DATA_W-1:0] sel);
      return ((dstat ^ sel[3:0]) & sel[19:16]) == 4'h0;
   endfunction
endpackage

// File: rtl/dma_ctl_dec.sv
module dma_ctl_dec
   import dma_ctl_pkg::*;
#(
   parameter int NUM_CHAN = 4,
   parameter int ADDR_W   = 12
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_CHAN-1:0] hit,
   output logic [WORD_W-1:0]   word
);
   localparam int CH_W = ADDR_W - WIN_LSB;

   logic unused_lsb;
   assign unused_lsb = ^addr[1:0];
   assign word = addr[WIN_LSB-1:2];

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_hit
      assign hit[c] = (addr[ADDR_W-1:WIN_LSB] == CH_W'(c));
   end
endmodule

// File: rtl/dma_ctl_chan.sv
module dma_ctl_chan
   import dma_ctl_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [WORD_W-1:0]  word,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               ev_kill,
   input  logic               ev_stop,
   input  logic               ev_bt_upd,
   input  logic               ev_bt_val,
   input  logic               flush_done,
   output logic [STAT_W-1:0]  status,
   output logic [DATA_W-1:0]  cmd_ptr,
   output logic               irq,
   output logic               load_req,
   output logic [NUM_SEL-1:0] cond,
   output logic [DATA_W-1:0]  rd_word
);
   logic [STAT_W-1:0] st_q, st_d;
   logic [DATA_W-1:0] ptr_q;
   logic [DATA_W-1:0] sel_q [NUM_SEL];
   logic              ptr_ok;

   always_comb begin
      st_d = st_q;
      if (wr_en && word == W_CTRL) st_d = ctl_merge(st_q, wdata);
      if (ev_bt_upd) st_d[B_BT] = ev_bt_val;
      if (flush_done) st_d[B_FLUSH] = 1'b0;
      if (ev_stop) begin
         st_d[B_ACT]  = 1'b0;
         st_d[B_DEAD] = 1'b0;
      end
      if (ev_kill) begin
         st_d[B_ACT]  = 1'b0;
         st_d[B_DEAD] = 1'b1;
      end
   end

   assign ptr_ok = wr_en && word == W_PTR && !(st_q[B_RUN] || st_q[B_ACT]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= '0;
         ptr_q    <= '0;
         irq      <= 1'b0;
         load_req <= 1'b0;
      end else begin
         st_q     <= st_d;
         irq      <= ev_kill;
         load_req <= ptr_ok;
         if (ptr_ok) ptr_q <= {wdata[DATA_W-1:4], 4'h0};
      end
   end

   for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
      localparam logic [WORD_W-1:0] SEL_WORD = W_ISEL + WORD_W'(s);
      always_ff @(posedge clk) begin
         if (!rst_n) sel_q[s] <= '0;
         else if (wr_en && word == SEL_WORD) sel_q[s] <= wdata;
      end
      assign cond[s] = sel_match(st_q[3:0], sel_q[s]);
   end

   always_comb begin
      rd_word = '0;
      if (word == W_STAT) rd_word = {{(DATA_W-STAT_W){1'b0}}, st_q};
      else if (word == W_PTR) rd_word = ptr_q;
      else if (word == W_ISEL + WORD_W'(SEL_INT)) rd_word = sel_q[SEL_INT];
      else if (word == W_ISEL + WORD_W'(SEL_BR)) rd_word = sel_q[SEL_BR];
      else if (word == W_ISEL + WORD_W'(SEL_WAIT)) rd_word = sel_q[SEL_WAIT];
   end

   assign status  = st_q;
   assign cmd_ptr = ptr_q;
endmodule

// File: rtl/dma_ctl_rdmux.sv
module dma_ctl_rdmux
   import dma_ctl_pkg::*;
#(
   parameter int NUM_CHAN = 4,
   parameter bit RD_PIPE  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       re,
   input  logic [NUM_CHAN-1:0]        hit,
   input  logic [NUM_CHAN*DATA_W-1:0] words,
   output logic [DATA_W-1:0]          rdata
);
   logic [DATA_W-1:0] pick;

   always_comb begin
      pick = '0;
      for (int c = 0; c < NUM_CHAN; c++)
         if (hit[c]) pick = pick | words[c*DATA_W +: DATA_W];
   end

   if (RD_PIPE) begin : g_pipe
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rd_q <= '0;
         else if (re) rd_q <= pick;
      end
      assign rdata = rd_q;
   end else begin : g_comb
      logic unused_rd;
      assign unused_rd = clk ^ rst_n ^ re;
      assign rdata = pick;
   end
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
   import dma_ctl_pkg::*;
#(
   parameter int NUM_CHAN = 4,
   parameter int ADDR_W   = 12,
   parameter bit RD_PIPE  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_we,
   input  logic                       bus_re,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [DATA_W-1:0]          bus_rdata,
   input  logic [NUM_CHAN-1:0]        ev_kill,
   input  logic [NUM_CHAN-1:0]        ev_stop,
   input  logic [NUM_CHAN-1:0]        ev_bt_upd,
   input  logic [NUM_CHAN-1:0]        ev_bt_val,
   input  logic [NUM_CHAN-1:0]        flush_done,
   output logic [NUM_CHAN-1:0]        run_o,
   output logic [NUM_CHAN-1:0]        pause_o,
   output logic [NUM_CHAN-1:0]        flush_o,
   output logic [NUM_CHAN-1:0]        wake_o,
   output logic [NUM_CHAN-1:0]        active_o,
   output logic [NUM_CHAN-1:0]        dead_o,
   output logic [NUM_CHAN-1:0]        irq_o,
   output logic [NUM_CHAN-1:0]        load_req_o,
   output logic [NUM_CHAN*DATA_W-1:0] cmd_ptr_o,
   output logic [NUM_CHAN-1:0]        int_cond_o,
   output logic [NUM_CHAN-1:0]        br_cond_o,
   output logic [NUM_CHAN-1:0]        wait_cond_o
);
   localparam int CH_W = ADDR_W - WIN_LSB;

   initial begin
      assert (ADDR_W > WIN_LSB) else $error("ADDR_W must exceed the window bits");
      assert (NUM_CHAN >= 1 && NUM_CHAN <= (1 << CH_W)) else $error("NUM_CHAN out of range");
   end

   logic [NUM_CHAN-1:0]        hit;
   logic [WORD_W-1:0]          word;
   logic [NUM_CHAN*DATA_W-1:0] words;

   dma_ctl_dec #(.NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W)) u_dec (
      .addr(bus_addr), .hit(hit), .word(word)
   );

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_ch
      logic [STAT_W-1:0]  st;
      logic [NUM_SEL-1:0] cnd;
      dma_ctl_chan u_chan (
         .clk(clk), .rst_n(rst_n),
         .wr_en(bus_we && hit[c]), .word(word), .wdata(bus_wdata),
         .ev_kill(ev_kill[c]), .ev_stop(ev_stop[c]),
         .ev_bt_upd(ev_bt_upd[c]), .ev_bt_val(ev_bt_val[c]),
         .flush_done(flush_done[c]),
         .status(st), .cmd_ptr(cmd_ptr_o[c*DATA_W +: DATA_W]),
         .irq(irq_o[c]), .load_req(load_req_o[c]), .cond(cnd),
         .rd_word(words[c*DATA_W +: DATA_W])
      );
      assign run_o[c]       = st[B_RUN];
      assign pause_o[c]     = st[B_PAUSE];
      assign flush_o[c]     = st[B_FLUSH];
      assign wake_o[c]      = st[B_WAKE];
      assign active_o[c]    = st[B_ACT];
      assign dead_o[c]      = st[B_DEAD];
      assign int_cond_o[c]  = cnd[SEL_INT];
      assign br_cond_o[c]   = cnd[SEL_BR];
      assign wait_cond_o[c] = cnd[SEL_WAIT];
   end

   dma_ctl_rdmux #(.NUM_CHAN(NUM_CHAN), .RD_PIPE(RD_PIPE)) u_rd (
      .clk(clk), .rst_n(rst_n), .re(bus_re), .hit(hit),
      .words(words), .rdata(bus_rdata)
   );
endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk #(
   parameter int NUM_CHAN = 4,
   parameter int ADDR_W   = 12,
   parameter bit RD_PIPE  = 1'b1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     bus_re,
   input logic [ADDR_W-1:0]        bus_addr,
   input logic [31:0]              bus_rdata,
   input logic [NUM_CHAN-1:0]      ev_kill,
   input logic [NUM_CHAN-1:0]      ev_stop,
   input logic [NUM_CHAN-1:0]      run_o,
   input logic [NUM_CHAN-1:0]      pause_o,
   input logic [NUM_CHAN-1:0]      active_o,
   input logic [NUM_CHAN-1:0]      dead_o,
   input logic [NUM_CHAN-1:0]      irq_o,
   input logic [NUM_CHAN-1:0]      load_req_o,
   input logic [NUM_CHAN*32-1:0]   cmd_ptr_o
);
   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chk
      AST_KILL_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
         ev_kill[c] |=> dead_o[c] && !active_o[c]); // R8
      AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[c] |-> $past(ev_kill[c])); // R8
      AST_PAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         pause_o[c] |-> !active_o[c]); // R4
      AST_RUN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(run_o[c]) |-> !active_o[c] && (!dead_o[c] || $past(ev_kill[c]))); // R5
      AST_PTR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
         (run_o[c] || active_o[c]) |=> $stable(cmd_ptr_o[c*32 +: 32])); // R6
      AST_LOAD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
         load_req_o[c] |-> cmd_ptr_o[c*32 +: 4] == 4'h0); // R6
      AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (ev_stop[c] && !ev_kill[c]) |=> !active_o[c] && !dead_o[c]); // R9
   end

   if (RD_PIPE) begin : g_rd
      AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_re && bus_addr[6:2] == 5'd0) |=> bus_rdata == 32'h0); // R7
   end
endmodule

bind dma_ctl_regs dma_ctl_regs_chk #(.NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W), .RD_PIPE(RD_PIPE)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_re(bus_re), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
   .ev_kill(ev_kill), .ev_stop(ev_stop), .run_o(run_o), .pause_o(pause_o),
   .active_o(active_o), .dead_o(dead_o), .irq_o(irq_o), .load_req_o(load_req_o),
   .cmd_ptr_o(cmd_ptr_o)
);

// File: tb/dma_ctl_regs_bench.sv
`timescale 1ns/1ps
module dma_ctl_regs_bench;
   localparam int N = 4;
   localparam int AW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_we = 1'b0, bus_re = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [N-1:0] ev_kill = '0, ev_stop = '0, ev_bt_upd = '0, ev_bt_val = '0, flush_done = '0;
   logic [N-1:0] run_o, pause_o, flush_o, wake_o, active_o, dead_o, irq_o, load_req_o;
   logic [N*32-1:0] cmd_ptr_o;
   logic [N-1:0] int_cond_o, br_cond_o, wait_cond_o;

   int n_chk = 0, n_err = 0;
   logic [15:0] m_st [N];
   logic [31:0] m_ptr [N];
   logic [31:0] rd;

   always #2.5 clk = ~clk;

   dma_ctl_regs u_dma_ctl_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_kill(ev_kill), .ev_stop(ev_stop),
      .ev_bt_upd(ev_bt_upd), .ev_bt_val(ev_bt_val), .flush_done(flush_done),
      .run_o(run_o), .pause_o(pause_o), .flush_o(flush_o), .wake_o(wake_o),
      .active_o(active_o), .dead_o(dead_o), .irq_o(irq_o), .load_req_o(load_req_o),
      .cmd_ptr_o(cmd_ptr_o), .int_cond_o(int_cond_o), .br_cond_o(br_cond_o),
      .wait_cond_o(wait_cond_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   function automatic logic [AW-1:0] adr(input int ch, input int word);
      return AW'((ch << 7) | (word << 2));
   endfunction

   // expected control merge built from R2..R5
   function automatic logic [15:0] exp_ctl(input logic [15:0] old, input logic [31:0] w);
      logic [15:0] en, v, n;
      en = w[31:16] & 16'hF0FF;
      v  = w[15:0] & 16'hF0FF;
      n  = (v & en) | (old & ~en);
      if (n[12]) n[10] = 1'b1;
      if (n[15]) begin n[10] = 1'b1; n[11] = 1'b0; end
      if (n[14]) n[10] = 1'b0;
      if (old[15] && !n[15]) begin n[10] = 1'b0; n[11] = 1'b0; end
      return n;
   endfunction

   task automatic bus_wr(input int ch, input int word, input logic [31:0] d);
      @(negedge clk);
      bus_addr = adr(ch, word); bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic ctl_wr(input int ch, input logic [31:0] d);
      bus_wr(ch, 0, d);
      if (ch < N) m_st[ch] = exp_ctl(m_st[ch], d);
   endtask

   task automatic bus_rd(input int ch, input int word, output logic [31:0] d);
      @(negedge clk);
      bus_addr = adr(ch, word); bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   task automatic evt(input logic [N-1:0] k, input logic [N-1:0] s, input logic [N-1:0] bu,
                      input logic [N-1:0] bv, input logic [N-1:0] fd);
      @(negedge clk);
      ev_kill = k; ev_stop = s; ev_bt_upd = bu; ev_bt_val = bv; flush_done = fd;
      @(negedge clk);
      ev_kill = '0; ev_stop = '0; ev_bt_upd = '0; ev_bt_val = '0; flush_done = '0;
   endtask

   task automatic chk_status(input string req, input int ch);
      logic [31:0] v;
      bus_rd(ch, 1, v);
      chk(req, v, {16'h0, m_st[ch]});
   endtask

   function automatic logic fm(input int d, input int m, input int v);
      return ((d & m) == (v & m));
   endfunction

   initial begin
      #(5.0 * 150000);
      n_err++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      for (int c = 0; c < N; c++) begin m_st[c] = '0; m_ptr[c] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      chk("R11 flags", {run_o, pause_o, flush_o, wake_o, active_o, dead_o, irq_o, load_req_o}, 32'h0);
      chk("R11 ptr", cmd_ptr_o[31:0] | cmd_ptr_o[127:96], 32'h0);
      for (int c = 0; c < N; c++) begin
         chk_status("R11 status", c);
         bus_rd(c, 4, rd); chk("R11 isel", rd, 32'h0);
      end

      // R2 R3 R4 R5: sweep enables and values of the four command bits
      for (int c = 0; c < N; c++) begin
         for (int k = 0; k < 256; k++) begin
            logic [31:0] w;
            w = {k[7:4], 4'hF, 8'h0F, k[3:0], 4'hF, 4'h0, k[3:0] ^ 4'(c)};
            ctl_wr(c, w);
            chk("R3/R4/R5 pins", {26'h0, run_o[c], pause_o[c], flush_o[c], wake_o[c], active_o[c], dead_o[c]},
                {26'h0, m_st[c][15], m_st[c][14], m_st[c][13], m_st[c][12], m_st[c][10], m_st[c][11]});
            chk_status("R2 merge", c);
         end
      end

      // R8 kill on a running channel
      ctl_wr(1, 32'hF000_8000);
      chk("R3 run active", {31'h0, active_o[1]}, 32'h1);
      evt(4'b0010, '0, '0, '0, '0);
      m_st[1][11] = 1'b1; m_st[1][10] = 1'b0;
      chk("R8 irq pulse", {28'h0, irq_o}, 32'h2);
      chk("R8 dead", {30'h0, dead_o[1], active_o[1]}, 32'h2);
      @(negedge clk);
      chk("R8 irq one cycle", {28'h0, irq_o}, 32'h0);
      chk_status("R8 status", 1);
      // R5 run falling clears DEAD and ACTIVE
      ctl_wr(1, 32'h8000_0000);
      chk("R5 cleared", {30'h0, dead_o[1], active_o[1]}, 32'h0);
      chk_status("R5 status", 1);
      // R3 run clears DEAD left by a kill
      evt(4'b0010, '0, '0, '0, '0);
      m_st[1][11] = 1'b1; m_st[1][10] = 1'b0;
      ctl_wr(1, 32'h8000_8000);
      chk("R3 dead cleared", {30'h0, dead_o[1], active_o[1]}, 32'h1);
      // R9 stop
      evt('0, 4'b0010, '0, '0, '0);
      m_st[1][11] = 1'b0; m_st[1][10] = 1'b0;
      chk_status("R9 stop", 1);
      // R8 kill beats stop and a control write
      @(negedge clk);
      bus_addr = adr(1, 0); bus_wdata = 32'h8000_8000; bus_we = 1'b1;
      ev_kill = 4'b0010; ev_stop = 4'b0010;
      @(negedge clk);
      bus_we = 1'b0; ev_kill = '0; ev_stop = '0;
      m_st[1] = exp_ctl(m_st[1], 32'h8000_8000); m_st[1][11] = 1'b1; m_st[1][10] = 1'b0;
      chk_status("R8 priority", 1);

      // R9 branch-taken and flush events
      evt('0, '0, 4'b0001, 4'b0001, '0);
      m_st[0][8] = 1'b1;
      chk_status("R9 bt set", 0);
      evt('0, '0, 4'b0001, 4'b0000, '0);
      m_st[0][8] = 1'b0;
      chk_status("R9 bt clear", 0);
      ctl_wr(0, 32'h2000_2000);
      chk("R9 flush set", {31'h0, flush_o[0]}, 32'h1);
      evt('0, '0, '0, '0, 4'b0001);
      m_st[0][13] = 1'b0;
      chk("R9 flush cleared", {31'h0, flush_o[0]}, 32'h0);

      // R6 pointer writes
      ctl_wr(2, 32'hF000_0000);
      evt('0, 4'b0100, '0, '0, '0);
      m_st[2][11] = 1'b0; m_st[2][10] = 1'b0;
      bus_wr(2, 3, 32'h1234_567F);
      chk("R6 load pulse", {28'h0, load_req_o}, 32'h4);
      chk("R6 aligned pin", cmd_ptr_o[64 +: 32], 32'h1234_5670);
      bus_rd(2, 3, rd); chk("R6 aligned read", rd, 32'h1234_5670);
      ctl_wr(2, 32'h1000_1000);
      bus_wr(2, 3, 32'hABCD_0000);
      chk("R6 no load when active", {28'h0, load_req_o}, 32'h0);
      bus_rd(2, 3, rd); chk("R6 locked active", rd, 32'h1234_5670);
      ctl_wr(2, 32'h9000_8000);
      evt('0, 4'b0100, '0, '0, '0);
      m_st[2][11] = 1'b0; m_st[2][10] = 1'b0;
      bus_wr(2, 3, 32'h5555_0000);
      bus_rd(2, 3, rd); chk("R6 locked run", rd, 32'h1234_5670);
      ctl_wr(2, 32'h8000_0000);
      bus_wr(2, 3, 32'h5555_0009);
      bus_rd(2, 3, rd); chk("R6 accepted", rd, 32'h5555_0000);

      // R7 readback map
      bus_rd(0, 0, rd); chk("R7 control zero", rd, 32'h0);
      bus_wr(0, 1, 32'hFFFF_FFFF);
      chk_status("R7 status write ignored", 0);
      for (int wd = 2; wd < 32; wd++) begin
         if (wd >= 3 && wd <= 6) continue;
         bus_wr(3, wd, 32'hFFFF_FFFF);
         bus_rd(3, wd, rd); chk("R7 unused zero", rd, 32'h0);
      end
      bus_wr(3, 4, 32'h000A_0005); bus_wr(3, 5, 32'h0003_0001); bus_wr(3, 6, 32'hDEAD_BEEF);
      bus_rd(3, 4, rd); chk("R7 isel", rd, 32'h000A_0005);
      bus_rd(3, 5, rd); chk("R7 bsel", rd, 32'h0003_0001);
      bus_rd(3, 6, rd); chk("R7 wsel", rd, 32'hDEAD_BEEF);

      // R1 channels beyond NUM_CHAN
      for (int c = N; c < 32; c += 5) begin
         bus_wr(c, 0, 32'hF0FF_F0FF);
         bus_wr(c, 4, 32'hFFFF_FFFF);
         bus_rd(c, 4, rd); chk("R1 out of range read", rd, 32'h0);
      end
      for (int c = 0; c < N; c++) chk_status("R1 no alias", c);

      // R10 condition sweep on channel 3
      for (int d = 0; d < 16; d++) begin
         ctl_wr(3, {16'h000F, 12'h0, 4'(d)});
         for (int s = 0; s < 256; s++) begin
            int m, v;
            m = s >> 4; v = s & 15;
            bus_wr(3, 4, {12'h0, 4'(m), 12'h0, 4'(v)});
            bus_wr(3, 5, {12'h0, 4'(m), 12'h0, 4'(v ^ 15)});
            bus_wr(3, 6, {12'h0, 4'(v), 12'h0, 4'(m)});
            chk("R10 cond", {29'h0, int_cond_o[3], br_cond_o[3], wait_cond_o[3]},
                {29'h0, fm(d, m, v), fm(d, m, v ^ 15), fm(d, v, m)});
         end
      end

      report();
   end
endmodule